// File: doc/BRIEF.md
# Partitioned Endpoint Packet Buffer

This block holds one shared byte RAM that is split into per-endpoint packet regions for a USB-style function controller. Endpoint 0 always owns the lowest 64 bytes, with a fixed 64-byte packet size and a single buffer. Endpoints 1 to 3 are set up through a configuration port. Each setup gives a base address, a region size, a maximum packet size, an isochronous flag and a double-buffer flag. A setup that breaks a sizing rule is refused and reported on `cfg_err`.

Packets enter on a byte-wide write stream and leave on a byte-wide read stream. Each stream selects its endpoint with an index input and uses valid/ready handshakes. A byte moves on a stream only in a cycle where both valid and ready are high. The sender may hold `wr_valid` with `wr_ready` low for any length of time, and it must keep the byte and its index stable until the handshake. The read side presents the byte combinationally. While `rd_ready` is low, the byte and `rd_last` stay put as long as `rd_ep` and the configuration do not change.

A double-buffered endpoint stores packets in two halves, each one maximum packet long. The producer can fill one half while the consumer drains the other. The end of every drained packet raises a one-cycle flag for that endpoint. After the enable input rises, the block waits three cycles before it serves any access.

Top module: `ep_packet_fifo`

## Requirements
- R1: `ready` goes high after three consecutive rising edges with `clk_en` high, and drops as soon as `clk_en` is sampled low. While `ready` is low, `wr_ready` and `rd_valid` are low, and any configuration request is refused.
- R2: Endpoint 0 is always configured with base 0, a maximum packet of 64 bytes and a single buffer. A configuration request that names endpoint 0 is refused.
- R3: A request is refused if its base is below 64 or if base plus size exceeds 4096. A refused request pulses `cfg_err` for one cycle, in the cycle after the request, and leaves the endpoint unchanged.
- R4: The maximum packet size must be between 1 and 64 when `cfg_iso` is 0, and between 1 and 1023 when `cfg_iso` is 1. Otherwise the request is refused.
- R5: The region size must be at least the maximum packet size, or at least twice that size when `cfg_dbl` is 1. Otherwise the request is refused.
- R6: `wr_ready` is high when the block is ready and the selected endpoint is unconfigured or its current producer half is empty. Accepted bytes are stored in arrival order, and a byte accepted with `wr_last` high ends and commits the packet.
- R7: `rd_valid` is high when the selected endpoint's current consumer half holds a committed packet. `rd_data` gives that packet's bytes in order, and `rd_last` marks its final byte.
- R8: A single-buffered endpoint accepts no new byte until its packet has been fully read. A double-buffered endpoint alternates halves for each packet: it can hold two committed packets and stalls only on a third.
- R9: `pkt_done[e]` pulses for one cycle, in the cycle after the handshake of the final byte of a packet on endpoint e.
- R10: Bytes past the maximum packet size within one packet are dropped, and the packet is committed with its first maximum-size bytes. `ep_ovf[e]` is set and stays set until endpoint e is reconfigured.
- R11: A write handshake on an unconfigured endpoint discards the byte. `rd_ready` high on an unconfigured endpoint moves nothing. Either case pulses `acc_err` in the next cycle.
- R12: An accepted configuration empties that endpoint, discarding any packets it holds, and restarts both its halves at half 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clk_en | input | 1 | Block enable; starts the start-up delay |
| ready | output | 1 | Block is able to serve accesses |
| cfg_we | input | 1 | Configuration request strobe |
| cfg_ep | input | 2 | Endpoint being configured |
| cfg_base | input | 12 | Region start byte address |
| cfg_size | input | 13 | Region length in bytes |
| cfg_mps | input | 10 | Maximum packet size in bytes |
| cfg_iso | input | 1 | Isochronous endpoint (raises packet limit) |
| cfg_dbl | input | 1 | Double-buffered region |
| cfg_err | output | 1 | Pulse: last request refused |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte accepted this cycle |
| wr_ep | input | 2 | Write endpoint index |
| wr_data | input | 8 | Write byte |
| wr_last | input | 1 | Byte ends the packet |
| rd_ready | input | 1 | Consumer takes the byte |
| rd_ep | input | 2 | Read endpoint index |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Read byte |
| rd_last | output | 1 | Byte is the packet's last |
| acc_err | output | 1 | Pulse: access to unconfigured endpoint |
| pkt_done | output | 4 | Per-endpoint packet-drained pulses |
| ep_ovf | output | 4 | Per-endpoint sticky overflow flags |

## Verification
A wrong half pointer or a stale valid bit would show at once in `wr_ready` or `rd_valid` for the selected endpoint. It would show no later than the first byte of the following packet, as a wrong `rd_data` value or a packet coming out of the wrong half. A wrong byte count shows as `rd_last` on the wrong byte and a `pkt_done` pulse one cycle off. A legality slip shows in `cfg_err` one cycle after the request, and afterwards as traffic on an endpoint that should have refused it. The reference model tracks each half's contents as queues and compares every output on every cycle, so any such drift is caught in the cycle it first reaches a port.

// File: rtl/epf_pkg.sv
package epf_pkg;
  parameter int NUM_EP    = 4;
  parameter int RAM_BYTES = 4096;
  parameter int EP0_BYTES = 64;
  parameter int MPS_STD   = 64;
  parameter int MPS_ISO   = 1023;
  parameter int READY_DLY = 3;
  parameter int DW        = 8;

  localparam int EPW  = $clog2(NUM_EP);
  localparam int AW   = $clog2(RAM_BYTES);
  localparam int SZW  = AW + 1;
  localparam int MPSW = $clog2(MPS_ISO + 1);
  localparam int DLYW = $clog2(READY_DLY + 1);

  typedef struct packed {
    logic            en;
    logic            dbl;
    logic [AW-1:0]   base;
    logic [MPSW-1:0] mps;
  } ep_cfg_t;

  localparam ep_cfg_t EP0_CFG = '{en: 1'b1, dbl: 1'b0, base: '0, mps: MPSW'(EP0_BYTES)};
endpackage

// File: rtl/epf_cfg.sv
module epf_cfg
  import epf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clk_en,
  input  logic                   cfg_we,
  input  logic [EPW-1:0]         cfg_ep,
  input  logic [AW-1:0]          cfg_base,
  input  logic [SZW-1:0]         cfg_size,
  input  logic [MPSW-1:0]        cfg_mps,
  input  logic                   cfg_iso,
  input  logic                   cfg_dbl,
  output logic                   ready,
  output logic                   cfg_err,
  output ep_cfg_t [NUM_EP-1:0]   tbl,
  output logic [NUM_EP-1:0]      load
);
  logic [DLYW-1:0] dly_q;
  logic            legal;
  int              lim;

  assign ready = (dly_q == DLYW'(READY_DLY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              dly_q <= '0;
    else if (!clk_en)                        dly_q <= '0;
    else if (dly_q != DLYW'(READY_DLY))      dly_q <= dly_q + 1'b1;
  end

  always_comb begin
    lim   = cfg_iso ? MPS_ISO : MPS_STD;
    legal = ready
         && (cfg_ep != '0) && (int'(cfg_ep) < NUM_EP)
         && (cfg_mps != '0) && (int'(cfg_mps) <= lim)
         && (int'(cfg_base) >= EP0_BYTES)
         && (int'(cfg_base) + int'(cfg_size) <= RAM_BYTES)
         && (int'(cfg_size) >= int'(cfg_mps) * (cfg_dbl ? 2 : 1));
    for (int i = 0; i < NUM_EP; i++)
      load[i] = cfg_we && legal && (cfg_ep == EPW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_err <= 1'b0;
      for (int i = 0; i < NUM_EP; i++)
        tbl[i] <= (i == 0) ? EP0_CFG : '0;
    end else begin
      cfg_err <= cfg_we && !legal;
      for (int i = 0; i < NUM_EP; i++)
        if (load[i])
          tbl[i] <= '{en: 1'b1, dbl: cfg_dbl, base: cfg_base, mps: cfg_mps};
    end
  end
endmodule

// File: rtl/epf_ep_ctrl.sv
module epf_ep_ctrl
  import epf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  ep_cfg_t       cfg,
  input  logic          load,
  input  logic          wr_fire,
  input  logic          wr_last,
  input  logic          rd_fire,
  output logic          wr_free,
  output logic          rd_avail,
  output logic          wr_store,
  output logic          rd_end,
  output logic          done,
  output logic          ovf,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr
);
  logic [1:0]      vld;
  logic [MPSW-1:0] cnt [2];
  logic [MPSW-1:0] wptr, rptr;
  logic            whalf, rhalf;

  assign wr_free  = cfg.en && !vld[whalf];
  assign rd_avail = cfg.en && vld[rhalf];
  assign wr_store = (wptr < cfg.mps);
  assign rd_end   = (rptr == cnt[rhalf] - MPSW'(1));
  assign wr_addr  = cfg.base + AW'(whalf ? cfg.mps : '0) + AW'(wptr);
  assign rd_addr  = cfg.base + AW'(rhalf ? cfg.mps : '0) + AW'(rptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0; cnt[0] <= '0; cnt[1] <= '0;
      wptr <= '0; rptr <= '0; whalf <= 1'b0; rhalf <= 1'b0;
      done <= 1'b0; ovf <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        vld <= '0; wptr <= '0; rptr <= '0;
        whalf <= 1'b0; rhalf <= 1'b0; ovf <= 1'b0;
      end else begin
        if (wr_fire) begin
          if (wr_store) wptr <= wptr + 1'b1;
          else          ovf  <= 1'b1;
          if (wr_last) begin
            vld[whalf] <= 1'b1;
            cnt[whalf] <= wr_store ? wptr + 1'b1 : wptr;
            wptr       <= '0;
            whalf      <= whalf ^ cfg.dbl;
          end
        end
        if (rd_fire) begin
          if (rd_end) begin
            vld[rhalf] <= 1'b0;
            rptr       <= '0;
            rhalf      <= rhalf ^ cfg.dbl;
            done       <= 1'b1;
          end else begin
            rptr <= rptr + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/epf_ram.sv
module epf_ram #(
  parameter int DEPTH = 4096,
  parameter int WIDTH = 8,
  localparam int AWL  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AWL-1:0]   waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AWL-1:0]   raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (we) mem[waddr] <= wdata;

  assign rdata = mem[raddr];
endmodule

// File: rtl/ep_packet_fifo.sv
module ep_packet_fifo
  import epf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clk_en,
  output logic                  ready,
  input  logic                  cfg_we,
  input  logic [EPW-1:0]        cfg_ep,
  input  logic [AW-1:0]         cfg_base,
  input  logic [SZW-1:0]        cfg_size,
  input  logic [MPSW-1:0]       cfg_mps,
  input  logic                  cfg_iso,
  input  logic                  cfg_dbl,
  output logic                  cfg_err,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [EPW-1:0]        wr_ep,
  input  logic [DW-1:0]         wr_data,
  input  logic                  wr_last,
  input  logic                  rd_ready,
  input  logic [EPW-1:0]        rd_ep,
  output logic                  rd_valid,
  output logic [DW-1:0]         rd_data,
  output logic                  rd_last,
  output logic                  acc_err,
  output logic [NUM_EP-1:0]     pkt_done,
  output logic [NUM_EP-1:0]     ep_ovf
);
  ep_cfg_t [NUM_EP-1:0]           tbl;
  logic [NUM_EP-1:0]              load;
  logic [NUM_EP-1:0]              wr_free_v, rd_avail_v, wr_store_v, rd_end_v;
  logic [NUM_EP-1:0]              wr_fire_v, rd_fire_v;
  logic [NUM_EP-1:0][AW-1:0]      wr_addr_v, rd_addr_v;
  logic                           wr_fire, ram_we;

  epf_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_mps(cfg_mps), .cfg_iso(cfg_iso), .cfg_dbl(cfg_dbl),
    .ready(ready), .cfg_err(cfg_err), .tbl(tbl), .load(load)
  );

  assign wr_ready = ready && (!tbl[wr_ep].en || wr_free_v[wr_ep]);
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_valid = ready && rd_avail_v[rd_ep];
  assign rd_last  = rd_valid && rd_end_v[rd_ep];
  assign ram_we   = wr_fire && tbl[wr_ep].en && wr_store_v[wr_ep];

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    assign wr_fire_v[i] = wr_fire && (wr_ep == EPW'(i)) && tbl[i].en;
    assign rd_fire_v[i] = rd_valid && rd_ready && (rd_ep == EPW'(i));

    epf_ep_ctrl u_ep (
      .clk(clk), .rst_n(rst_n), .cfg(tbl[i]), .load(load[i]),
      .wr_fire(wr_fire_v[i]), .wr_last(wr_last), .rd_fire(rd_fire_v[i]),
      .wr_free(wr_free_v[i]), .rd_avail(rd_avail_v[i]), .wr_store(wr_store_v[i]),
      .rd_end(rd_end_v[i]), .done(pkt_done[i]), .ovf(ep_ovf[i]),
      .wr_addr(wr_addr_v[i]), .rd_addr(rd_addr_v[i])
    );
  end

  epf_ram #(.DEPTH(RAM_BYTES), .WIDTH(DW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(wr_addr_v[wr_ep]), .wdata(wr_data),
    .raddr(rd_addr_v[rd_ep]), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_err <= 1'b0;
    else        acc_err <= (wr_fire && !tbl[wr_ep].en)
                        || (ready && rd_ready && !tbl[rd_ep].en);
  end
endmodule

// File: rtl/ep_packet_fifo_chk.sv
module ep_packet_fifo_chk
  import epf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              ready,
  input logic              cfg_we,
  input logic [EPW-1:0]    cfg_ep,
  input logic              cfg_err,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [EPW-1:0]    rd_ep,
  input logic [DW-1:0]     rd_data,
  input logic [NUM_EP-1:0] pkt_done,
  input logic [NUM_EP-1:0] ep_ovf
);
  p_ready_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(clk_en, 1) && $past(clk_en, 2) && $past(clk_en, 3)));

  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!wr_ready && !rd_valid));

  p_ep0_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_ep == '0) |=> cfg_err);

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !cfg_we && clk_en)
      |=> ((rd_ep != $past(rd_ep)) || (rd_valid && rd_data == $past(rd_data))));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pkt_done));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ((ep_ovf & $past(ep_ovf)) == $past(ep_ovf)));
endmodule

bind ep_packet_fifo ep_packet_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ready(ready),
  .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_err(cfg_err),
  .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_ep(rd_ep), .rd_data(rd_data), .pkt_done(pkt_done), .ep_ovf(ep_ovf)
);

// File: tb/ep_packet_fifo_tb.sv
module ep_packet_fifo_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0;
  logic cfg_we = 0, cfg_iso = 0, cfg_dbl = 0;
  logic [1:0] cfg_ep = 0, wr_ep = 0, rd_ep = 0;
  logic [11:0] cfg_base = 0;
  logic [12:0] cfg_size = 0;
  logic [9:0] cfg_mps = 0;
  logic wr_valid = 0, wr_last = 0, rd_ready = 0;
  logic [7:0] wr_data = 0;
  logic ready, cfg_err, wr_ready, rd_valid, rd_last, acc_err;
  logic [7:0] rd_data;
  logic [3:0] pkt_done, ep_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_packet_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ready(ready),
    .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_mps(cfg_mps), .cfg_iso(cfg_iso), .cfg_dbl(cfg_dbl), .cfg_err(cfg_err),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_ep(wr_ep), .wr_data(wr_data),
    .wr_last(wr_last), .rd_ready(rd_ready), .rd_ep(rd_ep), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_last(rd_last), .acc_err(acc_err),
    .pkt_done(pkt_done), .ep_ovf(ep_ovf)
  );

  int checks = 0, errors = 0;
  string phase = "R1";

  // reference model
  logic [7:0] mq [8][$];
  int m_en[4], m_mps[4], m_dbl[4], m_vld[4][2];
  int m_wcnt[4], m_wh[4], m_rh[4], m_rp[4];
  int m_rcnt = 0;
  bit [3:0] m_ovf = 0, m_done = 0;
  bit m_cfg_err = 0, m_acc_err = 0;
  bit last_wr_fire = 0, last_rd_end = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) actual=%0d expected=%0d at %0t", tag, phase, act, exp, $time);
    end
  endtask

  function automatic void flush(int e);
    mq[e*2].delete(); mq[e*2+1].delete();
    m_vld[e][0] = 0; m_vld[e][1] = 0;
    m_wcnt[e] = 0; m_wh[e] = 0; m_rh[e] = 0; m_rp[e] = 0; m_ovf[e] = 0;
  endfunction

  task automatic tick();
    bit e_rdy, e_wr, e_rd, rd_fire;
    int e, h, lim;
    bit legal, n_cfg, n_acc;
    bit [3:0] n_done;
    #1;
    e_rdy = (m_rcnt == 3);
    e_wr  = e_rdy && (m_en[wr_ep] == 0 || m_vld[wr_ep][m_wh[wr_ep]] == 0);
    e_rd  = e_rdy && m_en[rd_ep] != 0 && m_vld[rd_ep][m_rh[rd_ep]] != 0;
    chk("R1 ready", int'(ready), int'(e_rdy));
    chk("R6 wr_ready", int'(wr_ready), int'(e_wr));
    chk("R7 rd_valid", int'(rd_valid), int'(e_rd));
    chk("R3 cfg_err", int'(cfg_err), int'(m_cfg_err));
    chk("R11 acc_err", int'(acc_err), int'(m_acc_err));
    chk("R9 pkt_done", int'(pkt_done), int'(m_done));
    chk("R10 ep_ovf", int'(ep_ovf), int'(m_ovf));
    last_rd_end = 0;
    if (e_rd) begin
      e = int'(rd_ep); h = m_rh[e];
      chk("R7 rd_data", int'(rd_data), int'(mq[e*2+h][m_rp[e]]));
      chk("R7 rd_last", int'(rd_last), int'(m_rp[e] == mq[e*2+h].size() - 1));
      last_rd_end = rd_ready && (m_rp[e] == mq[e*2+h].size() - 1);
    end
    last_wr_fire = wr_valid && e_wr;
    rd_fire = e_rd && rd_ready;
    @(posedge clk);
    n_cfg = 0; n_acc = 0; n_done = 0;
    if (cfg_we) begin
      lim = cfg_iso ? 1023 : 64;
      legal = e_rdy && cfg_ep != 0 && cfg_mps >= 1 && int'(cfg_mps) <= lim
           && cfg_base >= 64 && int'(cfg_base) + int'(cfg_size) <= 4096
           && int'(cfg_size) >= int'(cfg_mps) * (cfg_dbl ? 2 : 1);
      if (legal) begin
        e = int'(cfg_ep);
        m_en[e] = 1; m_mps[e] = int'(cfg_mps); m_dbl[e] = int'(cfg_dbl);
        flush(e);
      end else n_cfg = 1;
    end else begin
      if (last_wr_fire) begin
        e = int'(wr_ep);
        if (m_en[e] == 0) n_acc = 1;
        else begin
          h = m_wh[e];
          if (m_wcnt[e] < m_mps[e]) begin mq[e*2+h].push_back(wr_data); m_wcnt[e]++; end
          else m_ovf[e] = 1;
          if (wr_last) begin m_vld[e][h] = 1; m_wcnt[e] = 0; m_wh[e] ^= m_dbl[e]; end
        end
      end
      if (e_rdy && rd_ready && m_en[rd_ep] == 0) n_acc = 1;
      if (rd_fire) begin
        e = int'(rd_ep); h = m_rh[e];
        if (m_rp[e] == mq[e*2+h].size() - 1) begin
          mq[e*2+h].delete(); m_vld[e][h] = 0; m_rp[e] = 0; m_rh[e] ^= m_dbl[e]; n_done[e] = 1;
        end else m_rp[e]++;
      end
    end
    if (!clk_en) m_rcnt = 0; else if (m_rcnt < 3) m_rcnt++;
    m_cfg_err = n_cfg; m_acc_err = n_acc; m_done = n_done;
    @(negedge clk);
  endtask

  task automatic do_cfg(int ep, int base, int size, int mps, bit iso, bit dbl, bit exp_err, string tag);
    cfg_we = 1; cfg_ep = 2'(ep); cfg_base = 12'(base); cfg_size = 13'(size);
    cfg_mps = 10'(mps); cfg_iso = iso; cfg_dbl = dbl;
    tick();
    cfg_we = 0;
    chk({tag, " cfg verdict"}, int'(cfg_err), int'(exp_err));
  endtask

  task automatic send_pkt(int ep, int n, int seed);
    int i = 0;
    wr_ep = 2'(ep);
    while (i < n) begin
      wr_valid = 1; wr_data = 8'(seed + i); wr_last = (i == n - 1);
      tick();
      if (last_wr_fire) i++;
    end
    wr_valid = 0; wr_last = 0;
  endtask

  task automatic read_pkt(int ep, bit stall);
    int cyc = 0;
    rd_ep = 2'(ep);
    last_rd_end = 0;
    while (!last_rd_end) begin
      rd_ready = stall ? cyc[0] : 1'b1;
      cyc++;
      tick();
    end
    rd_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired (%s)", phase);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int e = 0; e < 4; e++) begin
      m_en[e] = (e == 0); m_mps[e] = (e == 0) ? 64 : 0; m_dbl[e] = 0; flush(e);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state and start-up delay
    phase = "R1";
    chk("R1 reset ready", int'(ready), 0);
    chk("R1 reset ovf", int'(ep_ovf), 0);
    tick(); tick();
    do_cfg(1, 128, 64, 64, 0, 0, 1, "R1");
    clk_en = 1;
    tick(); tick();
    chk("R1 not yet ready", int'(ready), 0);
    tick();
    chk("R1 ready after delay", int'(ready), 1);
    // endpoint 0
    phase = "R2";
    do_cfg(0, 128, 64, 64, 0, 0, 1, "R2");
    send_pkt(0, 64, 8'h10);
    read_pkt(0, 0);
    chk("R2 R9 ep0 done", int'(pkt_done[0]), 1);
    // unconfigured access
    phase = "R11";
    send_pkt(1, 1, 8'h55);
    tick();
    rd_ep = 2; rd_ready = 1; tick(); rd_ready = 0;
    chk("R11 rd acc_err", int'(acc_err), 1);
    chk("R11 no rd_valid", int'(rd_valid), 0);
    tick();
    // legality
    phase = "R3";
    do_cfg(1, 32, 64, 64, 0, 0, 1, "R3");
    do_cfg(1, 4000, 200, 64, 0, 0, 1, "R3");
    phase = "R4";
    do_cfg(1, 128, 128, 65, 0, 0, 1, "R4");
    do_cfg(3, 1024, 1024, 1023, 1, 0, 0, "R4");
    do_cfg(3, 1024, 2048, 0, 1, 0, 1, "R4");
    phase = "R5";
    do_cfg(1, 128, 100, 64, 0, 1, 1, "R5");
    do_cfg(1, 128, 64, 64, 0, 0, 0, "R5");
    do_cfg(2, 256, 32, 16, 0, 1, 0, "R5");
    // single buffer stream
    phase = "R6";
    send_pkt(1, 10, 8'h30);
    wr_ep = 1; #1;
    chk("R8 single full stalls", int'(wr_ready), 0);
    phase = "R7";
    read_pkt(1, 1);
    chk("R9 ep1 done", int'(pkt_done[1]), 1);
    wr_ep = 1; #1;
    chk("R6 freed", int'(wr_ready), 1);
    tick();
    // double buffer
    phase = "R8";
    send_pkt(2, 16, 8'h80);
    send_pkt(2, 5, 8'hA0);
    wr_ep = 2; #1;
    chk("R8 third stalls", int'(wr_ready), 0);
    read_pkt(2, 0);
    chk("R9 ep2 done", int'(pkt_done[2]), 1);
    wr_ep = 2; #1;
    chk("R8 half free", int'(wr_ready), 1);
    tick();
    // overflow
    phase = "R10";
    send_pkt(2, 20, 8'hC0);
    chk("R10 ovf set", int'(ep_ovf[2]), 1);
    read_pkt(2, 0);
    read_pkt(2, 1);
    chk("R10 ovf sticky", int'(ep_ovf[2]), 1);
    // isochronous packet and reconfiguration flush
    phase = "R12";
    send_pkt(3, 200, 8'h07);
    rd_ep = 3; #1;
    chk("R12 iso packet held", int'(rd_valid), 1);
    tick();
    do_cfg(3, 1024, 1024, 512, 1, 0, 0, "R12");
    rd_ep = 3; #1;
    chk("R12 flushed", int'(rd_valid), 0);
    tick();
    do_cfg(2, 256, 32, 16, 0, 1, 0, "R12");
    chk("R12 R10 ovf cleared", int'(ep_ovf[2]), 0);
    send_pkt(3, 3, 8'hE0);
    read_pkt(3, 0);
    // enable drop
    phase = "R1";
    clk_en = 0;
    tick();
    chk("R1 drop", int'(ready), 0);
    tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule